// File: doc/BRIEF.md
# Rail Under-Voltage and Thermal Fault Monitor

This block supervises three supply rails and the die temperature from digitised readings. On every sample strobe it captures one code for each rail and one temperature code. It then updates a per-rail under-voltage state that has hysteresis, and a two-level thermal state. The combined result is one fault flag for the system and one latched request to shut down all rails on overheating.

An under-voltage condition only raises the fault flag and never removes power. A rail's check is masked while that rail is disabled. All rail checks are masked while soft-start is still running. Temperature works in two steps. The warning level raises the flag, and the higher level latches a shutdown request. The request is released only by a fresh soft-start once the sampled temperature is below the shutdown level. An external shutdown from the state controller holds the fault flag low.

Rail codes and temperature codes share the units of the converters that feed them: 10 mV per LSB for the rails and 1 °C per LSB for the temperature. Lane 0 of `rail_code` is the 3.3 V dual rail, lane 1 is the memory rail and lane 2 is the 5 V dual rail. The same bit order applies to `rail_en`.

Top module: `rail_fault_monitor`

## Requirements
- R1: 3.3 V dual rail (lane 0): under-voltage sets when a sampled code is below 224. It stays set for codes 224..246 and clears when a sampled code is 247 or more. A code of exactly 224 on a clean rail does not trip.
- R2: Memory rail (lane 1), set value 250: under-voltage sets below 68 % of the set value (code < 170). It clears only at a code of 187 or more, which is a further 7 % of the set value.
- R3: 5 V dual rail (lane 2): under-voltage sets below 340 and clears at 375 or more.
- R4: A rail whose `rail_en` bit is 0 never contributes to the fault flag, and its under-voltage state is discarded. When the rail is re-enabled, it is judged only on samples taken from then on.
- R5: While `ss_done` is 0, no rail contributes to the fault flag, and all rail states are discarded.
- R6: A sampled temperature code of 145 or more sets the fault flag without requesting shutdown. A code of 144 or less does not set the flag.
- R7: A sampled temperature code of 155 or more sets `therm_shdn`.
- R8: `therm_shdn` stays set after the temperature falls. It clears only on a `restart` pulse while the most recent temperature sample is below 155. A restart while the sample is still 155 or more is ignored.
- R9: While `ext_shdn` is 1, `fault` is 0.
- R10: `fault` is the OR of the unmasked rail under-voltage states and the temperature warning. After a strobe on clock edge k, the new value is visible after edge k+1. Input codes presented without a strobe have no effect.
- R11: After synchronous reset, `fault` and `therm_shdn` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld | input | 1 | Sample strobe; captures rail and temperature codes |
| rail_code | input | N_RAIL x CODE_W (3x10) | Rail readings, lane 0 = 3.3 V dual, 1 = memory, 2 = 5 V dual |
| rail_en | input | N_RAIL (3) | Per-rail enable; 0 masks that rail |
| ss_done | input | 1 | Soft-start finished; 0 masks all rails |
| temp_code | input | TEMP_W (8) | Die temperature in °C |
| ext_shdn | input | 1 | External shutdown; forces `fault` low |
| restart | input | 1 | Pulse at the start of a new soft-start |
| fault | output | 1 | Combined fault flag |
| therm_shdn | output | 1 | Latched thermal shutdown request |

## Verification
Each rail is driven with a code just below its trip point, a code inside its hysteresis band, a code one below release and a code exactly at release. This separates a plain threshold from a true hysteresis and catches off-by-one comparisons. The masks are checked with a deep under-voltage present, once with a rail disabled and once during soft-start. The rail is then re-enabled, which shows whether stale state survives a mask. Temperatures of 144, 145, 150 and 155 separate the warning from the shutdown level. Restarts given while hot and after cooling separate a latch from a level. A low reading held without a strobe, and the edge-by-edge timing after a strobe, confirm the sample-driven update.

// File: rtl/rail_mon_pkg.sv
package rail_mon_pkg;

    parameter int CODE_W = 10;
    parameter int TEMP_W = 8;
    parameter int N_RAIL = 3;

    typedef enum logic [1:0] {
        LANE_3V3_DUAL = 2'd0,
        LANE_MEMORY   = 2'd1,
        LANE_5V_DUAL  = 2'd2
    } rail_lane_e;

    // Trip point and release point of one rail, in reading units
    typedef struct packed {
        logic [CODE_W-1:0] trip;
        logic [CODE_W-1:0] rel;
    } uv_limit_t;

    // One captured set of readings
    typedef struct packed {
        logic [N_RAIL-1:0][CODE_W-1:0] rail;
        logic [TEMP_W-1:0]             temp;
    } sample_t;

    function automatic uv_limit_t limit_from_pct(int set_code, int trip_pct, int hyst_pct);
        uv_limit_t l;
        l.trip = CODE_W'((set_code * trip_pct) / 100);
        l.rel  = CODE_W'((set_code * trip_pct) / 100 + (set_code * hyst_pct) / 100);
        return l;
    endfunction

    function automatic uv_limit_t limit_from_abs(int trip_code, int hyst_code);
        uv_limit_t l;
        l.trip = CODE_W'(trip_code);
        l.rel  = CODE_W'(trip_code + hyst_code);
        return l;
    endfunction

endpackage

// File: rtl/uv_detector.sv
module uv_detector #(
    parameter int           W    = 10,
    parameter logic [W-1:0] TRIP = '0,
    parameter logic [W-1:0] REL  = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         upd,
    input  logic [W-1:0] code,
    input  logic         mask,
    output logic         uv
);

    always_ff @(posedge clk) begin
        if (rst || mask) begin
            uv <= 1'b0;
        end else if (upd) begin
            if (code < TRIP) begin
                uv <= 1'b1;
            end else if (code >= REL) begin
                uv <= 1'b0;
            end
        end
    end

    // R1, R2, R3: a trip only follows an update with a reading under the trip point
    assert_uv_set_R1: assert property (@(posedge clk) disable iff (rst)
        $rose(uv) |-> ($past(upd) && !$past(mask) && ($past(code) < TRIP)));

    // R4, R5: a release needs a mask or a reading at or above the release point
    assert_uv_release_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(uv) |-> ($past(mask) || ($past(upd) && ($past(code) >= REL))));

    // R5: a masked detector holds no state on the next edge
    assert_uv_masked_R5: assert property (@(posedge clk) disable iff (rst)
        mask |=> !uv);

endmodule

// File: rtl/thermal_guard.sv
module thermal_guard #(
    parameter int            TW   = 8,
    parameter logic [TW-1:0] WARN = '0,
    parameter logic [TW-1:0] SHDN = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          upd,
    input  logic [TW-1:0] temp,
    input  logic          restart,
    output logic          warn,
    output logic          shdn
);

    always_ff @(posedge clk) begin
        if (rst) begin
            warn <= 1'b0;
        end else if (upd) begin
            warn <= (temp >= WARN);
        end
    end

    // Set has priority; release needs a restart with a cool latest sample
    always_ff @(posedge clk) begin
        if (rst) begin
            shdn <= 1'b0;
        end else if (upd && (temp >= SHDN)) begin
            shdn <= 1'b1;
        end else if (restart && (temp < SHDN)) begin
            shdn <= 1'b0;
        end
    end

    assert_shdn_set_R7: assert property (@(posedge clk) disable iff (rst)
        (upd && (temp >= SHDN)) |=> shdn);

    assert_shdn_latched_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(shdn) |-> ($past(restart) && ($past(temp) < SHDN)));

    assert_warn_level_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(warn) |-> ($past(upd) && ($past(temp) >= WARN)));

endmodule

// File: rtl/rail_fault_monitor.sv
module rail_fault_monitor
    import rail_mon_pkg::*;
#(
    parameter int MEM_SET_CODE = 250,
    parameter int MEM_TRIP_PCT = 68,
    parameter int MEM_HYST_PCT = 7,
    parameter int V33_TRIP     = 224,
    parameter int V33_HYST     = 23,
    parameter int V5_TRIP      = 340,
    parameter int V5_HYST      = 35,
    parameter int TEMP_WARN    = 145,
    parameter int TEMP_SHDN    = 155
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           smp_vld,
    input  logic [N_RAIL-1:0][CODE_W-1:0]  rail_code,
    input  logic [N_RAIL-1:0]              rail_en,
    input  logic                           ss_done,
    input  logic [TEMP_W-1:0]              temp_code,
    input  logic                           ext_shdn,
    input  logic                           restart,
    output logic                           fault,
    output logic                           therm_shdn
);

    localparam logic [TEMP_W-1:0] WARN_CODE = TEMP_W'(TEMP_WARN);
    localparam logic [TEMP_W-1:0] SHDN_CODE = TEMP_W'(TEMP_SHDN);

    function automatic uv_limit_t limit_of(int lane);
        case (lane)
            int'(LANE_3V3_DUAL): return limit_from_abs(V33_TRIP, V33_HYST);
            int'(LANE_MEMORY):   return limit_from_pct(MEM_SET_CODE, MEM_TRIP_PCT, MEM_HYST_PCT);
            default:             return limit_from_abs(V5_TRIP, V5_HYST);
        endcase
    endfunction

    sample_t             samp_q;
    logic                upd_q;
    logic [N_RAIL-1:0]   rail_mask;
    logic [N_RAIL-1:0]   uv_state;
    logic                temp_warn;

    // Capture stage: readings are registered on the strobe
    always_ff @(posedge clk) begin
        if (rst) begin
            samp_q <= '0;
            upd_q  <= 1'b0;
        end else begin
            upd_q <= smp_vld;
            if (smp_vld) begin
                samp_q.rail <= rail_code;
                samp_q.temp <= temp_code;
            end
        end
    end

    assign rail_mask = ~rail_en | {N_RAIL{~ss_done}};

    for (genvar r = 0; r < N_RAIL; r++) begin : g_rail
        localparam uv_limit_t LIM = limit_of(r);
        uv_detector #(
            .W    (CODE_W),
            .TRIP (LIM.trip),
            .REL  (LIM.rel)
        ) uv_i (
            .clk  (clk),
            .rst  (rst),
            .upd  (upd_q),
            .code (samp_q.rail[r]),
            .mask (rail_mask[r]),
            .uv   (uv_state[r])
        );
    end

    thermal_guard #(
        .TW   (TEMP_W),
        .WARN (WARN_CODE),
        .SHDN (SHDN_CODE)
    ) therm_i (
        .clk     (clk),
        .rst     (rst),
        .upd     (upd_q),
        .temp    (samp_q.temp),
        .restart (restart),
        .warn    (temp_warn),
        .shdn    (therm_shdn)
    );

    assign fault = ~ext_shdn & ((|(uv_state & ~rail_mask)) | temp_warn);

    assert_fault_gated_R9: assert property (@(posedge clk) disable iff (rst)
        ext_shdn |-> !fault);

    // R10: the flag moves only after an update or a change of mask or shutdown input
    assert_fault_timing_R10: assert property (@(posedge clk) disable iff (rst)
        !$stable(fault) |-> ($past(upd_q) || !$stable(rail_en) || !$stable(ss_done)
                             || !$stable(ext_shdn)));

    // R11: nothing is flagged on the first edge out of reset
    assert_reset_quiet_R11: assert property (@(posedge clk)
        $past(rst) |-> !therm_shdn);

endmodule

// File: tb/rail_fault_monitor_tb_top.sv
module rail_fault_monitor_tb_top;

    localparam int CW = 10;
    localparam int TW = 8;

    typedef struct packed {
        logic [CW-1:0] r0;
        logic [CW-1:0] r1;
        logic [CW-1:0] r2;
        logic [TW-1:0] temp;
        logic [2:0]    en;
        logic          ss;
        logic          exp_fault;
        logic [7:0]    req;
    } vec_t;

    localparam int NVEC = 20;
    localparam vec_t VECS [NVEC] = '{
        '{10'd300, 10'd250, 10'd400, 8'd25,  3'b111, 1'b1, 1'b0, 8'd11},
        '{10'd223, 10'd250, 10'd400, 8'd25,  3'b111, 1'b1, 1'b1, 8'd1},
        '{10'd240, 10'd250, 10'd400, 8'd25,  3'b111, 1'b1, 1'b1, 8'd1},
        '{10'd247, 10'd250, 10'd400, 8'd25,  3'b111, 1'b1, 1'b0, 8'd1},
        '{10'd300, 10'd169, 10'd400, 8'd25,  3'b111, 1'b1, 1'b1, 8'd2},
        '{10'd300, 10'd186, 10'd400, 8'd25,  3'b111, 1'b1, 1'b1, 8'd2},
        '{10'd300, 10'd187, 10'd400, 8'd25,  3'b111, 1'b1, 1'b0, 8'd2},
        '{10'd300, 10'd250, 10'd339, 8'd25,  3'b111, 1'b1, 1'b1, 8'd3},
        '{10'd300, 10'd250, 10'd374, 8'd25,  3'b111, 1'b1, 1'b1, 8'd3},
        '{10'd300, 10'd250, 10'd375, 8'd25,  3'b111, 1'b1, 1'b0, 8'd3},
        '{10'd224, 10'd250, 10'd400, 8'd25,  3'b111, 1'b1, 1'b0, 8'd1},
        '{10'd300, 10'd100, 10'd400, 8'd25,  3'b101, 1'b1, 1'b0, 8'd4},
        '{10'd300, 10'd100, 10'd400, 8'd25,  3'b111, 1'b1, 1'b1, 8'd4},
        '{10'd300, 10'd250, 10'd400, 8'd25,  3'b111, 1'b1, 1'b0, 8'd4},
        '{10'd100, 10'd100, 10'd100, 8'd25,  3'b111, 1'b0, 1'b0, 8'd5},
        '{10'd100, 10'd100, 10'd100, 8'd25,  3'b111, 1'b1, 1'b1, 8'd5},
        '{10'd300, 10'd250, 10'd400, 8'd25,  3'b111, 1'b1, 1'b0, 8'd5},
        '{10'd300, 10'd250, 10'd400, 8'd144, 3'b111, 1'b1, 1'b0, 8'd6},
        '{10'd300, 10'd250, 10'd400, 8'd145, 3'b111, 1'b1, 1'b1, 8'd6},
        '{10'd300, 10'd250, 10'd400, 8'd100, 3'b111, 1'b1, 1'b0, 8'd6}
    };

    logic                clk = 1'b0;
    logic                rst;
    logic                smp_vld;
    logic [2:0][CW-1:0]  rail_code;
    logic [2:0]          rail_en;
    logic                ss_done;
    logic [TW-1:0]       temp_code;
    logic                ext_shdn;
    logic                restart;
    logic                fault;
    logic                therm_shdn;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    rail_fault_monitor dut_i (
        .clk        (clk),
        .rst        (rst),
        .smp_vld    (smp_vld),
        .rail_code  (rail_code),
        .rail_en    (rail_en),
        .ss_done    (ss_done),
        .temp_code  (temp_code),
        .ext_shdn   (ext_shdn),
        .restart    (restart),
        .fault      (fault),
        .therm_shdn (therm_shdn)
    );

    task automatic check(input string req, input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic set_inputs(input logic [CW-1:0] a, input logic [CW-1:0] b,
                              input logic [CW-1:0] c, input logic [TW-1:0] t,
                              input logic [2:0] en, input logic ss);
        rail_code[0] = a;
        rail_code[1] = b;
        rail_code[2] = c;
        temp_code    = t;
        rail_en      = en;
        ss_done      = ss;
    endtask

    // Called at a negedge; returns at the negedge after the result edge
    task automatic strobe();
        smp_vld = 1'b1;
        @(negedge clk);
        smp_vld = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_restart();
        restart = 1'b1;
        @(negedge clk);
        restart = 1'b0;
    endtask

    initial begin
        rst = 1'b1; smp_vld = 1'b0; ext_shdn = 1'b0; restart = 1'b0;
        set_inputs(10'd300, 10'd250, 10'd400, 8'd25, 3'b111, 1'b1);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R11", "fault after reset", fault, 1'b0);
        check("R11", "therm_shdn after reset", therm_shdn, 1'b0);

        // Table walk
        for (int i = 0; i < NVEC; i++) begin
            set_inputs(VECS[i].r0, VECS[i].r1, VECS[i].r2, VECS[i].temp, VECS[i].en, VECS[i].ss);
            strobe();
            check($sformatf("R%0d", VECS[i].req), $sformatf("vector %0d fault", i), fault, VECS[i].exp_fault);
        end

        // R10: reading without strobe is ignored; result lands after second edge
        set_inputs(10'd100, 10'd250, 10'd400, 8'd25, 3'b111, 1'b1);
        repeat (3) @(negedge clk);
        check("R10", "no strobe, low reading", fault, 1'b0);
        smp_vld = 1'b1;
        @(negedge clk);
        smp_vld = 1'b0;
        check("R10", "one edge after strobe", fault, 1'b0);
        @(negedge clk);
        check("R10", "two edges after strobe", fault, 1'b1);

        // R9: external shutdown holds the flag low
        ext_shdn = 1'b1;
        #1;
        check("R9", "fault under ext_shdn", fault, 1'b0);
        @(negedge clk);
        check("R9", "fault under ext_shdn next cycle", fault, 1'b0);
        ext_shdn = 1'b0;
        #1;
        check("R9", "fault after ext_shdn release", fault, 1'b1);
        set_inputs(10'd300, 10'd250, 10'd400, 8'd25, 3'b111, 1'b1);
        @(negedge clk);
        strobe();
        check("R1", "recovered before thermal tests", fault, 1'b0);

        // R6 / R7: warning versus shutdown
        temp_code = 8'd150;
        strobe();
        check("R6", "150 C fault", fault, 1'b1);
        check("R6", "150 C no shutdown", therm_shdn, 1'b0);
        temp_code = 8'd155;
        strobe();
        check("R7", "155 C shutdown", therm_shdn, 1'b1);
        check("R7", "155 C fault", fault, 1'b1);

        // R8: latch survives hot restart and cooling, clears on cool restart
        pulse_restart();
        @(negedge clk);
        check("R8", "restart while hot", therm_shdn, 1'b1);
        temp_code = 8'd120;
        strobe();
        check("R8", "cooled, no restart", therm_shdn, 1'b1);
        check("R6", "cooled, warning gone", fault, 1'b0);
        pulse_restart();
        check("R8", "restart after cooling", therm_shdn, 1'b0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule